// File: doc/BRIEF.md
# Voice Activity Detector with Hang-over

This block decides, sample by sample, whether a transmit voice stream carries speech. Each time the sample strobe pulses it takes one signed linear sample, folds its magnitude into a short-term energy estimate, and compares that estimate against one of four selectable detection levels. When the estimate stays above the chosen level for about 5 ms the presence flag rises. Once set, the flag is held through pauses and drops only after a selectable stretch of continuous silence of 160 ms or 320 ms.

Alongside the binary decision the block reports a 2-bit coarse level code that places the current energy into one of four bands. Both outputs are meaningful only while the enable input is high. While it is low they read zero and all internal state is cleared, so a later enable starts detection from scratch. Samples arrive at 8 kHz, one per strobe. The block does not care how many clock cycles lie between strobes.

Top module: `vad_detector`

## Requirements
- R1: The energy estimate is a leaky average of sample magnitude: on each strobe the accumulator becomes acc - (acc >> 5) + |sample|, and the estimate is acc >> 5. A constant magnitude M therefore settles to an estimate of exactly M. The magnitude of the most negative sample is 8192.
- R2: With the 0 dBm0 reference magnitude at 3600, the threshold select chooses the detection level: 00 gives 113 (-30 dBm0), 01 gives 64 (-35 dBm0), 10 gives 36 (-40 dBm0) and 11 gives 20 (-45 dBm0). A reading counts as above only when the estimate is strictly greater than the level.
- R3: While the flag is clear, it sets on the 40th consecutive strobe whose reading is above the level (about 5 ms). A reading that is not above restarts this count.
- R4: With hang-over select 0, a set flag clears on the 1280th consecutive strobe whose reading is not above the level (160 ms).
- R5: With hang-over select 1, the flag clears on the 2560th such strobe (320 ms).
- R6: Any reading above the level while the flag is set restarts the hang-over count from zero.
- R7: The level code is 11 when the estimate exceeds 36 (-40 dBm0), 10 when it exceeds 11 (-50 dBm0), 01 when it exceeds 3 (-60 dBm0), and 00 otherwise.
- R8: While enable is 0, the flag and level code read 0 and the estimate, counters and flag are cleared. After enable returns to 1, a full attack period is needed again.
- R9: The flag and the level code change only on a clock edge where a strobe was taken, or when enable changes.
- R10: After reset the flag and the level code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Signed two's complement linear sample |
| strobe_i | input | 1 | One-cycle pulse that takes in sample_i |
| en_i | input | 1 | Detector enable |
| thr_sel_i | input | 2 | Detection level select |
| hang_sel_i | input | 1 | Hang-over select: 0 for 160 ms, 1 for 320 ms |
| presence_o | output | 1 | Speech present flag |
| level_o | output | 2 | Coarse energy band code |

## Verification
Constant-magnitude streams of alternating sign settle the estimate to a known value. Four magnitudes place it in each level band, which separates the band edges and shows that negative samples count by their magnitude. A magnitude of 50 lies between neighbouring detection levels, so it tells each threshold code apart. A loud burst followed by silence times the attack and both hang-over lengths inside narrow windows. A short burst in the middle of a hang-over shows the count restarting. Dropping enable while the flag is set, then raising it again, shows the outputs forced to zero and the attack starting over.

// File: rtl/vad_pkg.sv
package vad_pkg;

    // Scale a reference magnitude down by a power ratio given in thousandths.
    function automatic int unsigned vad_scale(input int unsigned ref_mag,
                                              input int unsigned ratio_x1000);
        return (ref_mag * 1000) / ratio_x1000;
    endfunction

    typedef enum logic [1:0] {
        LVL_QUIET = 2'b00,
        LVL_LOW   = 2'b01,
        LVL_MID   = 2'b10,
        LVL_HIGH  = 2'b11
    } vad_level_e;

endpackage

// File: rtl/vad_energy.sv
module vad_energy #(
    parameter int SAMPLE_W = 14,
    parameter int WIN_LOG2 = 5,
    localparam int ACC_W   = SAMPLE_W + WIN_LOG2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clr_i,
    input  logic                       strobe_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic        [SAMPLE_W-1:0] avg_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } energy_t;

    energy_t st_d, st_q;
    logic [SAMPLE_W-1:0] mag;

    always_comb begin
        // Two's complement negate; the most negative code maps to its unsigned magnitude
        mag = sample_i[SAMPLE_W-1] ? SAMPLE_W'(-sample_i) : SAMPLE_W'(sample_i);
        st_d = st_q;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (strobe_i) begin
            st_d.acc = st_q.acc - (st_q.acc >> WIN_LOG2) + ACC_W'(mag);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign avg_o = SAMPLE_W'(st_q.acc >> WIN_LOG2);

endmodule

// File: rtl/vad_level.sv
module vad_level #(
    parameter int AVG_W = 14,
    parameter int TH_LO = 3,
    parameter int TH_MD = 11,
    parameter int TH_HI = 36
) (
    input  logic [AVG_W-1:0] avg_i,
    output logic [1:0]       level_o
);
    import vad_pkg::*;

    localparam logic [AVG_W-1:0] LIM_LO = AVG_W'(TH_LO);
    localparam logic [AVG_W-1:0] LIM_MD = AVG_W'(TH_MD);
    localparam logic [AVG_W-1:0] LIM_HI = AVG_W'(TH_HI);

    vad_level_e band;

    always_comb begin
        if (avg_i > LIM_HI)      band = LVL_HIGH;
        else if (avg_i > LIM_MD) band = LVL_MID;
        else if (avg_i > LIM_LO) band = LVL_LOW;
        else                     band = LVL_QUIET;
        level_o = band;
    end

endmodule

// File: rtl/vad_hangover.sv
module vad_hangover #(
    parameter int ATTACK_N   = 40,
    parameter int HANG_SHORT = 1280,
    parameter int HANG_LONG  = 2560,
    localparam int ATK_W     = $clog2(ATTACK_N + 1),
    localparam int HNG_W     = $clog2(HANG_LONG + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             strobe_i,
    input  logic             above_i,
    input  logic             hang_sel_i,
    output logic             flag_o,
    output logic [ATK_W-1:0] atk_cnt_o,
    output logic [HNG_W-1:0] hang_cnt_o
);

    localparam logic [ATK_W-1:0] ATK_LAST = ATK_W'(ATTACK_N - 1);
    localparam logic [HNG_W-1:0] HNG_S    = HNG_W'(HANG_SHORT - 1);
    localparam logic [HNG_W-1:0] HNG_L    = HNG_W'(HANG_LONG - 1);

    typedef struct packed {
        logic             flag;
        logic [ATK_W-1:0] atk;
        logic [HNG_W-1:0] hang;
    } hang_t;

    hang_t st_d, st_q;
    logic [HNG_W-1:0] hang_last;

    always_comb begin
        hang_last = hang_sel_i ? HNG_L : HNG_S;
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (strobe_i) begin
            if (above_i) begin
                st_d.hang = '0;
                if (!st_q.flag) begin
                    if (st_q.atk >= ATK_LAST) begin
                        st_d.flag = 1'b1;
                        st_d.atk  = '0;
                    end else begin
                        st_d.atk = st_q.atk + 1'b1;
                    end
                end
            end else begin
                st_d.atk = '0;
                if (st_q.flag) begin
                    if (st_q.hang >= hang_last) begin
                        st_d.flag = 1'b0;
                        st_d.hang = '0;
                    end else begin
                        st_d.hang = st_q.hang + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o     = st_q.flag;
    assign atk_cnt_o  = st_q.atk;
    assign hang_cnt_o = st_q.hang;

endmodule

// File: rtl/vad_detector.sv
module vad_detector #(
    parameter int SAMPLE_W   = 14,
    parameter int WIN_LOG2   = 5,
    parameter int REF_MAG    = 3600,
    parameter int ATTACK_N   = 40,
    parameter int HANG_SHORT = 1280,
    parameter int HANG_LONG  = 2560
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       strobe_i,
    input  logic                       en_i,
    input  logic [1:0]                 thr_sel_i,
    input  logic                       hang_sel_i,
    output logic                       presence_o,
    output logic [1:0]                 level_o
);
    import vad_pkg::*;

    localparam int ATK_W = $clog2(ATTACK_N + 1);
    localparam int HNG_W = $clog2(HANG_LONG + 1);

    // Detection levels, -30/-35/-40/-45 dBm0 relative to REF_MAG
    localparam logic [SAMPLE_W-1:0] TH_30 = SAMPLE_W'(vad_scale(REF_MAG, 31623));
    localparam logic [SAMPLE_W-1:0] TH_35 = SAMPLE_W'(vad_scale(REF_MAG, 56234));
    localparam logic [SAMPLE_W-1:0] TH_40 = SAMPLE_W'(vad_scale(REF_MAG, 100000));
    localparam logic [SAMPLE_W-1:0] TH_45 = SAMPLE_W'(vad_scale(REF_MAG, 177828));
    // Band edges for the level code, -50/-60 dBm0
    localparam int BAND_50 = int'(vad_scale(REF_MAG, 316228));
    localparam int BAND_60 = int'(vad_scale(REF_MAG, 1000000));
    localparam int BAND_40 = int'(vad_scale(REF_MAG, 100000));

    logic                clr;
    logic [SAMPLE_W-1:0] avg;
    logic [SAMPLE_W-1:0] thr;
    logic                above;
    logic                flag;
    logic [1:0]          level_raw;
    logic [ATK_W-1:0]    atk_cnt;
    logic [HNG_W-1:0]    hang_cnt;

    assign clr = !en_i;

    vad_energy #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_energy (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .strobe_i (strobe_i),
        .sample_i (sample_i),
        .avg_o    (avg)
    );

    always_comb begin
        unique case (thr_sel_i)
            2'b00:   thr = TH_30;
            2'b01:   thr = TH_35;
            2'b10:   thr = TH_40;
            default: thr = TH_45;
        endcase
        above = avg > thr;
    end

    vad_hangover #(
        .ATTACK_N   (ATTACK_N),
        .HANG_SHORT (HANG_SHORT),
        .HANG_LONG  (HANG_LONG)
    ) u_hang (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (clr),
        .strobe_i   (strobe_i),
        .above_i    (above),
        .hang_sel_i (hang_sel_i),
        .flag_o     (flag),
        .atk_cnt_o  (atk_cnt),
        .hang_cnt_o (hang_cnt)
    );

    vad_level #(
        .AVG_W (SAMPLE_W),
        .TH_LO (BAND_60),
        .TH_MD (BAND_50),
        .TH_HI (BAND_40)
    ) u_level (
        .avg_i   (avg),
        .level_o (level_raw)
    );

    assign presence_o = en_i & flag;
    assign level_o    = en_i ? level_raw : 2'b00;

endmodule

// File: rtl/vad_detector_chk.sv
module vad_detector_chk #(
    parameter int ATTACK_N   = 40,
    parameter int HANG_SHORT = 1280,
    parameter int HANG_LONG  = 2560,
    parameter int ATK_W      = 6,
    parameter int HNG_W      = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             strobe_i,
    input logic             en_i,
    input logic             hang_sel_i,
    input logic             presence_o,
    input logic [1:0]       level_o,
    input logic             flag,
    input logic [ATK_W-1:0] atk_cnt,
    input logic [HNG_W-1:0] hang_cnt
);

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && !$past(strobe_i)) |-> ($stable(presence_o) && $stable(level_o))); // R9

    AST_ATTACK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        atk_cnt < ATK_W'(ATTACK_N)); // R3

    AST_HANG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hang_cnt < HNG_W'(HANG_LONG)); // R5

    AST_RELEASE_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(flag) && $past(en_i)) |->
            ($past(hang_cnt) >= ($past(hang_sel_i) ? HNG_W'(HANG_LONG - 1) : HNG_W'(HANG_SHORT - 1)))); // R4

    AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!flag && atk_cnt == '0 && hang_cnt == '0)); // R8

endmodule

bind vad_detector vad_detector_chk #(
    .ATTACK_N   (ATTACK_N),
    .HANG_SHORT (HANG_SHORT),
    .HANG_LONG  (HANG_LONG),
    .ATK_W      (ATK_W),
    .HNG_W      (HNG_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .en_i       (en_i),
    .hang_sel_i (hang_sel_i),
    .presence_o (presence_o),
    .level_o    (level_o),
    .flag       (flag),
    .atk_cnt    (atk_cnt),
    .hang_cnt   (hang_cnt)
);

// File: tb/vad_detector_bench.sv
module vad_detector_bench;

    logic               clk_i = 1'b0;
    logic               rst_ni = 1'b0;
    logic signed [13:0] sample_i = '0;
    logic               strobe_i = 1'b0;
    logic               en_i = 1'b1;
    logic [1:0]         thr_sel_i = 2'b00;
    logic               hang_sel_i = 1'b0;
    logic               presence_o;
    logic [1:0]         level_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk_i = ~clk_i;

    vad_detector u_vad_detector (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sample_i   (sample_i),
        .strobe_i   (strobe_i),
        .en_i       (en_i),
        .thr_sel_i  (thr_sel_i),
        .hang_sel_i (hang_sel_i),
        .presence_o (presence_o),
        .level_o    (level_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // n samples of magnitude mag, alternating sign when alt is set
    task automatic feed(input int n, input int mag, input bit alt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            sample_i = (alt && i[0]) ? 14'(-mag) : 14'(mag);
            strobe_i = 1'b1;
            @(negedge clk_i);
            strobe_i = 1'b0;
            @(negedge clk_i);
            @(negedge clk_i);
        end
    endtask

    task automatic restart(input logic [1:0] thr, input logic hs);
        @(negedge clk_i);
        rst_ni = 1'b0;
        en_i = 1'b1;
        thr_sel_i = thr;
        hang_sel_i = hs;
        strobe_i = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic t_reset();
        restart(2'b00, 1'b0);
        chk(presence_o == 1'b0, "R10 flag", int'(presence_o), 0);
        chk(level_o == 2'b00, "R10 level", int'(level_o), 0);
    endtask

    task automatic t_levels();
        int mags[4] = '{2, 5, 20, 100};
        int exps[4] = '{0, 1, 2, 3};
        for (int k = 0; k < 4; k++) begin
            restart(2'b00, 1'b0);
            feed(400, mags[k], 1'b1);
            chk(int'(level_o) == exps[k], "R7 R1 level band", int'(level_o), exps[k]);
        end
        restart(2'b00, 1'b0);
        feed(400, -8192, 1'b0);
        chk(level_o == 2'b11, "R1 most negative sample", int'(level_o), 3);
    endtask

    task automatic t_thresholds();
        // magnitude 50 sits between the -35 (64) and -40 (36) levels
        restart(2'b00, 1'b0);
        feed(300, 50, 1'b1);
        chk(presence_o == 1'b0, "R2 sel 00 below", int'(presence_o), 0);
        restart(2'b01, 1'b0);
        feed(300, 50, 1'b1);
        chk(presence_o == 1'b0, "R2 sel 01 below", int'(presence_o), 0);
        restart(2'b10, 1'b0);
        feed(300, 50, 1'b1);
        chk(presence_o == 1'b1, "R2 sel 10 above", int'(presence_o), 1);
        restart(2'b11, 1'b0);
        feed(300, 50, 1'b1);
        chk(presence_o == 1'b1, "R2 sel 11 above", int'(presence_o), 1);
        // 30 is above -45 (20) but below -40 (36)
        restart(2'b10, 1'b0);
        feed(300, 30, 1'b1);
        chk(presence_o == 1'b0, "R2 sel 10 with 30", int'(presence_o), 0);
    endtask

    task automatic t_attack();
        restart(2'b00, 1'b0);
        feed(36, 2000, 1'b1);
        chk(presence_o == 1'b0, "R3 before attack", int'(presence_o), 0);
        feed(12, 2000, 1'b1);
        chk(presence_o == 1'b1, "R3 after attack", int'(presence_o), 1);
    endtask

    task automatic t_hang(input logic hs, input int hold);
        restart(2'b00, hs);
        feed(300, 2000, 1'b1);
        feed(hold, 0, 1'b0);
        chk(presence_o == 1'b1, hs ? "R5 held" : "R4 held", int'(presence_o), 1);
        feed(200, 0, 1'b0);
        chk(presence_o == 1'b0, hs ? "R5 released" : "R4 released", int'(presence_o), 0);
    endtask

    task automatic t_long_outlasts_short();
        restart(2'b00, 1'b1);
        feed(300, 2000, 1'b1);
        feed(1480, 0, 1'b0);
        chk(presence_o == 1'b1, "R5 still held past short", int'(presence_o), 1);
    endtask

    task automatic t_restart_hang();
        restart(2'b00, 1'b0);
        feed(300, 2000, 1'b1);
        feed(1000, 0, 1'b0);
        feed(10, 2000, 1'b1);
        feed(1200, 0, 1'b0);
        chk(presence_o == 1'b1, "R6 hang restarted", int'(presence_o), 1);
        feed(300, 0, 1'b0);
        chk(presence_o == 1'b0, "R6 released after restart", int'(presence_o), 0);
    endtask

    task automatic t_enable();
        restart(2'b00, 1'b0);
        feed(300, 2000, 1'b1);
        chk(presence_o == 1'b1, "R8 set before disable", int'(presence_o), 1);
        @(negedge clk_i);
        en_i = 1'b0;
        #1;
        chk(presence_o == 1'b0, "R8 flag forced", int'(presence_o), 0);
        chk(level_o == 2'b00, "R8 level forced", int'(level_o), 0);
        feed(20, 2000, 1'b1);
        chk(presence_o == 1'b0 && level_o == 2'b00, "R8 stays zero while off", int'(presence_o), 0);
        @(negedge clk_i);
        en_i = 1'b1;
        feed(20, 2000, 1'b1);
        chk(presence_o == 1'b0, "R8 attack restarts", int'(presence_o), 0);
        feed(30, 2000, 1'b1);
        chk(presence_o == 1'b1, "R8 set after new attack", int'(presence_o), 1);
    endtask

    task automatic t_no_strobe();
        restart(2'b00, 1'b0);
        feed(50, 2000, 1'b1);
        @(negedge clk_i);
        sample_i = '0;
        repeat (100) @(negedge clk_i);
        chk(presence_o == 1'b1 && level_o == 2'b11, "R9 hold without strobe", int'(level_o), 3);
    endtask

    initial begin
        t_reset();
        t_levels();
        t_thresholds();
        t_attack();
        t_hang(1'b0, 1280);
        t_hang(1'b1, 2560);
        t_long_outlasts_short();
        t_restart_hang();
        t_enable();
        t_no_strobe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule